// File: doc/BRIEF.md
# DDC EDID Read Controller

This block is the host side of a display identification link. On a start request it masters a two-wire bus through open-drain enables. When asked, it first writes a segment number to the segment pointer device at 7-bit address 0x30. It then addresses the identification device at 7-bit address 0x50 and sets its byte offset to zero. Finally it reads one 128-byte block in a single sequential burst. Each received byte leaves on a one-cycle valid strobe together with its index within the block. At the end the block raises a done pulse that carries a checksum verdict, or an error pulse that says whether the display refused to acknowledge or held the clock line for too long.

Every line change is paced by a settle delay given as a cycle count. A display that stretches the clock is waited for. A display that is powered down or stuck cannot hang the controller: a clock held low past the stall limit aborts the transfer and releases both lines, and a missing acknowledge ends the transfer with a STOP and an error, never with a retry.

Top module: `ddc_edid_reader`

## Requirements
- R1: After reset, and whenever the block is idle, both line enables are low (lines released) and busy, done and error are low.
- R2: Without a segment request the bus sees START, byte 0xA0, byte 0x00, a repeated START, byte 0xA1, 128 read bytes, then STOP. The bytes appear on the byte stream in order, each with index 0 to 127 equal to its position.
- R3: With a segment request the bus first sees START, byte 0x60 and the segment byte. A repeated START then leads straight into the R2 sequence with no STOP in between, so the data comes from the selected segment.
- R4: The controller acknowledges (drives SDA low) each of the first 127 read bytes and leaves the 128th unacknowledged (SDA released).
- R5: After releasing SCL the controller waits as long as the sampled SCL stays low (clock stretching). A stretched transfer completes with correct data.
- R6: A byte written by the controller that is not acknowledged (SDA high in the ninth clock) ends the transfer with a STOP and an error pulse whose timeout flag is 0. No done pulse follows.
- R7: If SCL stays low for TIMEOUT_CYCLES consecutive cycles while the controller waits for it, the controller releases both lines at once, sends no STOP, and pulses error with the timeout flag set to 1.
- R8: A start request that arrives while busy is ignored and does not alter the transfer in progress.
- R9: Done is a one-cycle pulse. The checksum flag presented with it is 1 exactly when the 128 bytes sum to zero modulo 256.
- R10: A start request presented in the very cycle that done is high is accepted, and busy is high in the next cycle.
- R11: Outside START and STOP conditions, SDA changes only while SCL is low. Each transfer therefore shows exactly one START per addressing phase and exactly one STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request a block read (sampled when idle) |
| seg_en_i | input | 1 | Write a segment number before the read |
| seg_i | input | 8 | Segment number |
| scl_oe_o | output | 1 | Pull SCL low when 1 |
| sda_oe_o | output | 1 | Pull SDA low when 1 |
| scl_i | input | 1 | Sampled SCL line level |
| sda_i | input | 1 | Sampled SDA line level |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle pulse on successful completion |
| csum_ok_o | output | 1 | Block sums to zero; valid with done |
| err_o | output | 1 | One-cycle pulse on failure |
| err_timeout_o | output | 1 | With err: 1 for clock stall, 0 for missing acknowledge |
| byte_valid_o | output | 1 | Received byte strobe |
| byte_o | output | 8 | Received byte |
| byte_idx_o | output | $clog2(BLOCK_BYTES) | Index of the received byte in the block |

## Verification
The two functions that can meet in one cycle are the completion pulse of one transfer and the acceptance of the next start request. The bench raises start at the very sample where it first sees done. It then requires busy to be high one cycle later, the first block's data and checksum verdict to be intact, and the second transfer to show its own segment write, start count and data. A second collision, a start request pulsed in the middle of a transfer with a different segment, is judged by the block still arriving from the original segment with the original number of STARTs.

// File: rtl/ddc_edid_reader.sv
module ddc_edid_reader #(
  parameter int STEP_CYCLES    = 8000,
  parameter int TIMEOUT_CYCLES = 440000,
  parameter int BLOCK_BYTES    = 128,
  parameter logic [6:0] SEG_DEV  = 7'h30,
  parameter logic [6:0] EDID_DEV = 7'h50
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           start_i,
  input  logic                           seg_en_i,
  input  logic [7:0]                     seg_i,
  output logic                           scl_oe_o,
  output logic                           sda_oe_o,
  input  logic                           scl_i,
  input  logic                           sda_i,
  output logic                           busy_o,
  output logic                           done_o,
  output logic                           csum_ok_o,
  output logic                           err_o,
  output logic                           err_timeout_o,
  output logic                           byte_valid_o,
  output logic [7:0]                     byte_o,
  output logic [$clog2(BLOCK_BYTES)-1:0] byte_idx_o
);
  localparam int DW = $clog2(STEP_CYCLES + 1);
  localparam int TW = $clog2(TIMEOUT_CYCLES + 1);
  localparam int IW = $clog2(BLOCK_BYTES);
  localparam logic [3:0] OP_READ = 4'd8;
  localparam logic [3:0] OP_STOP = 4'd9;

  typedef enum logic [3:0] {
    IDLE, S_A, S_B, S_C, S_D, B_A, B_B, B_C, P_A, P_B, P_C, P_D
  } st_t;

  st_t           state;
  logic [DW-1:0] dly;
  logic [TW-1:0] stall;
  logic [1:0]    scl_s, sda_s;
  logic [3:0]    op, bitn;
  logic [7:0]    txb, rxb, seg_r, csum;
  logic [IW-1:0] nbyte;
  logic          nack;

  wire scl_h      = scl_s[1];
  wire sda_h      = sda_s[1];
  wire wait_st    = (state == S_C) || (state == B_C) || (state == P_C);
  wire stalled    = wait_st && !scl_h;
  wire step_done  = dly == DW'(STEP_CYCLES - 1);
  wire timeout    = stalled && (stall == TW'(TIMEOUT_CYCLES - 1));
  wire is_rd      = op == OP_READ;
  wire last_byte  = nbyte == IW'(BLOCK_BYTES - 1);
  wire [3:0] nop  = op + 4'd1;
  wire bit_low    = (bitn != 4'd8) ? (!is_rd && !txb[7]) : (is_rd && !last_byte);

  assign busy_o = state != IDLE;

  function automatic st_t op_state(input logic [3:0] o);
    case (o)
      4'd0, 4'd3, 4'd6: op_state = S_A;
      OP_STOP:          op_state = P_A;
      default:          op_state = B_A;
    endcase
  endfunction

  function automatic logic [7:0] op_byte(input logic [3:0] o, input logic [7:0] s);
    case (o)
      4'd1:    op_byte = {SEG_DEV, 1'b0};
      4'd2:    op_byte = s;
      4'd4:    op_byte = {EDID_DEV, 1'b0};
      4'd7:    op_byte = {EDID_DEV, 1'b1};
      default: op_byte = 8'h00;
    endcase
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_s <= 2'b11;
      sda_s <= 2'b11;
    end else begin
      scl_s <= {scl_s[0], scl_i};
      sda_s <= {sda_s[0], sda_i};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state         <= IDLE;
      dly           <= '0;
      stall         <= '0;
      op            <= '0;
      bitn          <= '0;
      txb           <= '0;
      rxb           <= '0;
      seg_r         <= '0;
      csum          <= '0;
      nbyte         <= '0;
      nack          <= 1'b0;
      scl_oe_o      <= 1'b0;
      sda_oe_o      <= 1'b0;
      done_o        <= 1'b0;
      csum_ok_o     <= 1'b0;
      err_o         <= 1'b0;
      err_timeout_o <= 1'b0;
      byte_valid_o  <= 1'b0;
      byte_o        <= '0;
      byte_idx_o    <= '0;
    end else begin
      done_o       <= 1'b0;
      err_o        <= 1'b0;
      byte_valid_o <= 1'b0;
      if (state == IDLE) begin
        dly   <= '0;
        stall <= '0;
        if (start_i) begin
          state         <= S_A;
          op            <= seg_en_i ? 4'd0 : 4'd3;
          seg_r         <= seg_i;
          csum          <= '0;
          nbyte         <= '0;
          nack          <= 1'b0;
          bitn          <= '0;
          err_timeout_o <= 1'b0;
        end
      end else if (timeout) begin
        state         <= IDLE;
        scl_oe_o      <= 1'b0;
        sda_oe_o      <= 1'b0;
        err_o         <= 1'b1;
        err_timeout_o <= 1'b1;
      end else if (stalled) begin
        dly   <= '0;
        stall <= stall + 1'b1;
      end else if (!step_done) begin
        dly   <= dly + 1'b1;
        stall <= '0;
      end else begin
        dly   <= '0;
        stall <= '0;
        case (state)
          S_A: begin sda_oe_o <= 1'b0; state <= S_B; end
          S_B: begin scl_oe_o <= 1'b0; state <= S_C; end
          S_C: begin sda_oe_o <= 1'b1; state <= S_D; end
          S_D: begin
            scl_oe_o <= 1'b1;
            op       <= nop;
            state    <= op_state(nop);
            txb      <= op_byte(nop, seg_r);
            bitn     <= '0;
          end
          B_A: begin sda_oe_o <= bit_low; state <= B_B; end
          B_B: begin scl_oe_o <= 1'b0; state <= B_C; end
          B_C: begin
            scl_oe_o <= 1'b1;
            if (bitn != 4'd8) begin
              bitn  <= bitn + 4'd1;
              txb   <= {txb[6:0], 1'b0};
              rxb   <= {rxb[6:0], sda_h};
              state <= B_A;
            end else if (!is_rd) begin
              if (sda_h) begin
                nack  <= 1'b1;
                op    <= OP_STOP;
                state <= P_A;
              end else begin
                op    <= nop;
                state <= op_state(nop);
                txb   <= op_byte(nop, seg_r);
                bitn  <= '0;
              end
            end else begin
              byte_valid_o <= 1'b1;
              byte_o       <= rxb;
              byte_idx_o   <= nbyte;
              csum         <= csum + rxb;
              bitn         <= '0;
              if (last_byte) begin
                op    <= OP_STOP;
                state <= P_A;
              end else begin
                nbyte <= nbyte + 1'b1;
                state <= B_A;
              end
            end
          end
          P_A: begin sda_oe_o <= 1'b1; state <= P_B; end
          P_B: begin scl_oe_o <= 1'b0; state <= P_C; end
          P_C: begin sda_oe_o <= 1'b0; state <= P_D; end
          P_D: begin
            state <= IDLE;
            if (nack) begin
              err_o         <= 1'b1;
              err_timeout_o <= 1'b0;
            end else begin
              done_o    <= 1'b1;
              csum_ok_o <= (csum == 8'h00);
            end
          end
          default: state <= IDLE;
        endcase
      end
    end
  end

  assert_idle_released_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (!scl_oe_o && !sda_oe_o));

  assert_byte_in_xfer_R2: assert property (@(posedge clk) disable iff (!rst_n)
    byte_valid_o |-> busy_o);

  assert_scl_wait_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == B_C && !scl_h) |=> (state == B_C || err_o));

  assert_err_not_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> !done_o);

  assert_timeout_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (err_o && err_timeout_o) |-> !$past(scl_h));

  assert_seg_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && $past(busy_o)) |-> $stable(seg_r));

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  assert_sda_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (state == B_C && $past(state) == B_C) |-> $stable(sda_oe_o));
endmodule

// File: tb/ddc_edid_reader_bench.sv
`timescale 1ns/1ps
module ddc_edid_reader_bench;
  localparam int STEP = 3;
  localparam int TO   = 200;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic       rst_n = 1'b0, start_i = 1'b0, seg_en_i = 1'b0;
  logic [7:0] seg_i = 8'h00;
  logic       scl_oe, sda_oe, busy, done, csum_ok, err, err_to, bv;
  logic [7:0] bdata;
  logic [6:0] bidx;
  logic       s_scl_low = 1'b0, s_sda_low = 1'b0;
  wire        scl_bus = !(scl_oe || s_scl_low);
  wire        sda_bus = !(sda_oe || s_sda_low);

  ddc_edid_reader #(.STEP_CYCLES(STEP), .TIMEOUT_CYCLES(TO), .BLOCK_BYTES(128)) u_ddc_edid_reader (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .seg_en_i(seg_en_i), .seg_i(seg_i),
    .scl_oe_o(scl_oe), .sda_oe_o(sda_oe), .scl_i(scl_bus), .sda_i(sda_bus),
    .busy_o(busy), .done_o(done), .csum_ok_o(csum_ok), .err_o(err), .err_timeout_o(err_to),
    .byte_valid_o(bv), .byte_o(bdata), .byte_idx_o(bidx));

  int checks = 0, fails = 0, cyc = 0;
  bit present = 1'b1, hold = 1'b0, corrupt = 1'b0;
  int stretch_len = 0;
  int starts = 0, stops = 0, acks = 0, nacks = 0, wn = 0, cn = 0;
  logic [7:0] wlog [8];
  logic [7:0] gd [128];
  int         gi [128];

  function automatic logic [7:0] eb(input int blk, input int i, input bit bad);
    int s;
    s = 0;
    if (i < 127) return 8'((blk * 31 + i * 7 + 3) & 255);
    for (int k = 0; k < 127; k++) s += (blk * 31 + k * 7 + 3) & 255;
    return 8'(((256 - (s % 256)) % 256 + int'(bad)) & 255);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      if (cyc > 190000) begin
        checks++;
        fails++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, 190000);
        summary();
      end
    end
  end

  initial begin
    forever begin
      @(negedge clk);
      if (bv) begin
        if (cn < 128) begin
          gd[cn] = bdata;
          gi[cn] = int'(bidx);
        end
        cn++;
      end
    end
  end

  initial begin
    int st, bitc, tcnt, scnt, dev;
    bit first, rd, mack, ps, pd, cs, cd;
    logic [7:0] sh, tb, segreg, ptr;
    st = 0; bitc = 0; tcnt = 0; scnt = 0; dev = 0;
    first = 0; rd = 0; mack = 1; ps = 1; pd = 1;
    sh = 0; tb = 0; segreg = 0; ptr = 0;
    forever begin
      @(negedge clk);
      cs = scl_bus;
      cd = sda_bus;
      if (scnt > 0) scnt--;
      if (ps && cs && pd && !cd) begin
        if (present) begin
          starts++;
          st = 1; bitc = 0; first = 1; s_sda_low = 0;
        end
      end else if (ps && cs && !pd && cd) begin
        stops++;
        st = 0; segreg = 0; s_sda_low = 0;
      end else if (!ps && cs) begin
        if (st == 1) begin
          sh = {sh[6:0], cd};
          bitc++;
        end else if (st == 4) mack = cd;
      end else if (ps && !cs) begin
        if (stretch_len > 0) scnt = stretch_len;
        if (st == 1 && bitc == 8) begin
          if (wn < 8) wlog[wn] = sh;
          wn++;
          if (first) begin
            first = 0;
            if (sh[7:1] == 7'h50) begin dev = 2; rd = sh[0]; st = 2; s_sda_low = 1; end
            else if (sh[7:1] == 7'h30 && !sh[0]) begin dev = 1; rd = 0; st = 2; s_sda_low = 1; end
            else begin st = 0; s_sda_low = 0; end
          end else begin
            if (dev == 1) segreg = sh; else ptr = sh;
            st = 2; s_sda_low = 1;
          end
        end else if (st == 2 || (st == 4 && !mack)) begin
          if (st == 4) acks++;
          if (rd) begin
            tb = eb(int'(segreg) * 2 + int'(ptr[7]), int'(ptr[6:0]), corrupt);
            ptr = ptr + 8'd1;
            s_sda_low = !tb[7];
            tcnt = 1;
            st = 3;
          end else begin
            s_sda_low = 0; st = 1; bitc = 0;
          end
        end else if (st == 4) begin
          nacks++;
          st = 0; s_sda_low = 0;
        end else if (st == 3) begin
          if (tcnt == 8) begin s_sda_low = 0; st = 4; end
          else begin s_sda_low = !tb[7 - tcnt]; tcnt++; end
        end
      end
      s_scl_low = hold || (scnt > 0);
      ps = cs;
      pd = cd;
    end
  end

  task automatic setup(input bit bad, input int stretch);
    starts = 0; stops = 0; acks = 0; nacks = 0; wn = 0; cn = 0;
    corrupt = bad;
    stretch_len = stretch;
  endtask

  task automatic start_req(input bit use_seg, input int seg);
    seg_en_i = use_seg;
    seg_i = 8'(seg);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic wait_end(output bit d, output bit e, output int n);
    n = 0;
    while (!done && !err && n < 60000) begin
      @(negedge clk);
      n++;
    end
    d = done;
    e = err;
    if (n >= 60000) chk(1'b0, "end-of-transfer", n, 60000);
  endtask

  task automatic finish_check(input bit use_seg, input int seg, input int blk, input bit bad, input bit pw);
    bit d, e;
    int n, s, nw;
    logic [7:0] ew [5];
    string rq;
    wait_end(d, e, n);
    rq = use_seg ? "R3" : "R2";
    chk(d && !e, rq, {d, e}, 2);
    chk(cn == 128, "R2 byte count", cn, 128);
    s = 0;
    for (int i = 0; i < 128; i++) begin
      chk(gd[i] == eb(blk, i, bad), rq, gd[i], eb(blk, i, bad));
      chk(gi[i] == i, "R2 index", gi[i], i);
      s += eb(blk, i, bad);
    end
    chk(csum_ok == ((s % 256) == 0), "R9 checksum", csum_ok, (s % 256) == 0);
    chk(starts == (use_seg ? 3 : 2), "R11 starts", starts, use_seg ? 3 : 2);
    chk(stops == 1, "R11 stops", stops, 1);
    chk(acks == 127, "R4 acks", acks, 127);
    chk(nacks == 1, "R4 final nack", nacks, 1);
    if (use_seg) begin
      ew[0] = 8'h60; ew[1] = 8'(seg); ew[2] = 8'hA0; ew[3] = 8'h00; ew[4] = 8'hA1; nw = 5;
    end else begin
      ew[0] = 8'hA0; ew[1] = 8'h00; ew[2] = 8'hA1; ew[3] = 0; ew[4] = 0; nw = 3;
    end
    chk(wn == nw, "R3 written byte count", wn, nw);
    for (int i = 0; i < nw; i++) chk(wlog[i] == ew[i], rq, wlog[i], ew[i]);
    if (pw) begin
      @(negedge clk);
      chk(!done && !busy, "R9 done pulse", done, 0);
    end
  endtask

  initial begin
    bit d, e;
    int n;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!scl_oe && !sda_oe, "R1 lines", {scl_oe, sda_oe}, 0);
    chk(!busy && !done && !err, "R1 flags", {busy, done, err}, 0);

    setup(0, 0); start_req(0, 0); finish_check(0, 0, 0, 0, 1);
    for (int sg = 1; sg <= 2; sg++) begin
      setup(sg == 2, 0); start_req(1, sg); finish_check(1, sg, 2 * sg, sg == 2, 1);
    end

    setup(0, 7); start_req(0, 0); finish_check(0, 0, 0, 0, 1);  // R5
    stretch_len = 0;

    setup(0, 0); start_req(0, 0);
    repeat (400) @(negedge clk);
    chk(busy, "R8 busy", busy, 1);
    start_req(1, 2);
    finish_check(0, 0, 0, 0, 1);  // R8

    setup(0, 0); start_req(1, 1); finish_check(1, 1, 2, 0, 0);
    setup(0, 0);
    start_req(0, 0);
    chk(busy, "R10 back-to-back accept", busy, 1);
    finish_check(0, 0, 0, 0, 1);

    present = 1'b0;
    setup(0, 0); start_req(0, 0);
    wait_end(d, e, n);
    chk(e && !err_to && !d, "R6 nack error", {e, err_to, d}, 4);
    chk(cn == 0, "R6 no bytes", cn, 0);
    @(negedge clk);
    chk(stops == 1 && !done, "R6 stop sent", stops, 1);
    present = 1'b1;

    hold = 1'b1;
    repeat (3) @(negedge clk);
    setup(0, 0); start_req(0, 0);
    wait_end(d, e, n);
    chk(e && err_to, "R7 timeout error", {e, err_to}, 3);
    chk(n >= TO && n <= TO + 16, "R7 timeout window", n, TO);
    chk(!scl_oe && !sda_oe && !busy, "R7 lines released", {scl_oe, sda_oe, busy}, 0);
    chk(stops == 0, "R7 no stop", stops, 0);
    hold = 1'b0;
    repeat (20) @(negedge clk);
    chk(!scl_oe && !sda_oe && !busy && !done && !err, "R1 idle after abort", {scl_oe, sda_oe}, 0);
    summary();
  end
endmodule